// File: doc/BRIEF.md
# AHB-Lite Single-Requester Address Decoder and Response Steering

This block sits between one AHB-Lite requester and a small set of responders. In each address phase it compares the requester's address against a parameterised base/mask region per responder. It raises exactly one responder select, choosing the lowest-indexed region when regions overlap. When an address phase completes, the block records which responder was chosen and holds that record through the data phase. It then routes that responder's ready, read data and response back to the requester.

The returned ready is chosen from the responders rather than formed as an AND of all their ready outputs. While a data phase is outstanding, the recorded responder's ready drives the requester. With nothing outstanding, the ready of the responder decoded in the current address phase is used. There is therefore a combinational path from the address to the returned ready. The chosen ready is also broadcast to every responder's ready input. Addresses that hit no region are answered by an internal default responder with a two-cycle error.

Top module: `ahbl_addr_steer`

## Requirements
- R1: `rsp_hsel` has bit i set only when `(req_haddr & MASK[i]) == (BASE[i] & MASK[i])` and no lower index also matches, and it is all zero when no region matches. Defaults: region 0 is 0x0000_0000/0xFFFF_F000, region 1 is 0x0001_0000/0xFFFF_F000, and region 2 is 0x0001_0000/0xFFFF_0000, so 0x0001_0xxx goes to region 1.
- R2: With no data phase outstanding and an active transfer (`req_htrans[1]`=1, which covers NONSEQ=2'b10 and SEQ=2'b11) to a mapped address, `req_hready` equals `rsp_hreadyout` of the decoded responder.
- R3: A data-phase record is loaded on a rising clock edge where `req_hready` is 1 and the transfer is active. It is held while `req_hready` is 0 and cleared on an edge where `req_hready` is 1 and the transfer is IDLE (2'b00) or BUSY (2'b01).
- R4: While a mapped responder's data phase is outstanding, `req_hready` equals that responder's `rsp_hreadyout`, whatever the current address decodes to.
- R5: `rsp_hready` always carries the same value as `req_hready`.
- R6: `req_hrdata` and `req_hresp` come from the responder whose data phase is outstanding. With nothing outstanding, they are 0 and OKAY. `hresp` encoding: 0 = OKAY, 1 = ERROR.
- R7: With no data phase outstanding and an inactive transfer type, `req_hready` is 1.
- R8: An active transfer to an unmapped address is accepted with `req_hready` taken as 1. Its data phase is answered by the default responder: first cycle `req_hready`=0 with `req_hresp`=1, second cycle `req_hready`=1 with `req_hresp`=1, and `req_hrdata`=0 in both.
- R9: While `rst` is high (synchronous, active high), the record is cleared, so `req_hready` is 1 when the transfer is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_haddr | input | ADDR_W | Requester address |
| req_htrans | input | 2 | Requester transfer type |
| req_hready | output | 1 | Combined ready returned to requester |
| req_hrdata | output | DATA_W | Read data returned to requester |
| req_hresp | output | 1 | Response returned to requester (1 = ERROR) |
| rsp_hsel | output | N_RESP | One-hot responder select from address decode |
| rsp_hready | output | 1 | Combined ready broadcast to all responders |
| rsp_hreadyout | input | N_RESP | Per-responder ready output |
| rsp_hrdata | input | N_RESP*DATA_W | Per-responder read data, responder i at bits [i*DATA_W +: DATA_W] |
| rsp_hresp | input | N_RESP | Per-responder response |

## Verification
Directed sequences cover the distinct cases of the design. Single transfers with wait states check that the recorded responder, not the live decode, owns the ready. Back-to-back transfers to different responders expose a record that is updated a cycle late. Addresses in the overlap of regions 1 and 2 check the lowest-index priority. Unmapped addresses, alone and followed at once by a mapped transfer, pin down the two-cycle error and its hand-over. A long stretch with random addresses drawn from the region edges, random transfer types and random responder ready, data and response separates decoding faults from steering faults cycle by cycle.

// File: rtl/ahbl_steer_pkg.sv
package ahbl_steer_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic RESP_OKAY = 1'b0;
  localparam logic RESP_ERR  = 1'b1;

  function automatic logic trans_active(input logic [1:0] t);
    return (t == TR_NONSEQ) || (t == TR_SEQ);
  endfunction
endpackage

// File: rtl/ahbl_region_dec.sv
module ahbl_region_dec #(
  parameter int N_RESP = 3,
  parameter int ADDR_W = 32,
  parameter logic [N_RESP*ADDR_W-1:0] RGN_BASE = '0,
  parameter logic [N_RESP*ADDR_W-1:0] RGN_MASK = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_RESP-1:0] sel,
  output logic              miss
);
  logic [N_RESP-1:0] hit;

  // one comparator per region
  for (genvar i = 0; i < N_RESP; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] B = RGN_BASE[i*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] M = RGN_MASK[i*ADDR_W +: ADDR_W];
    assign hit[i] = ((addr & M) == (B & M));
  end

  // lowest index wins on overlap
  always_comb begin
    logic taken;
    taken = 1'b0;
    sel   = '0;
    for (int i = 0; i < N_RESP; i++) begin
      if (hit[i] && !taken) begin
        sel[i] = 1'b1;
        taken  = 1'b1;
      end
    end
    miss = !taken;
  end
endmodule

// File: rtl/ahbl_phase_track.sv
module ahbl_phase_track #(
  parameter int N_RESP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hready,
  input  logic              active,
  input  logic [N_RESP-1:0] dec_sel,
  input  logic              dec_miss,
  output logic [N_RESP-1:0] pend_sel,
  output logic              pend_dflt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_sel  <= '0;
      pend_dflt <= 1'b0;
    end else if (hready) begin
      pend_sel  <= active ? dec_sel : '0;
      pend_dflt <= active && dec_miss;
    end
  end
endmodule

// File: rtl/ahbl_dflt_resp.sv
module ahbl_dflt_resp (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic pend_dflt,
  output logic dflt_ready,
  output logic dflt_resp
);
  import ahbl_steer_pkg::*;
  logic first_q;

  always_ff @(posedge clk) begin
    if (rst) first_q <= 1'b0;
    else     first_q <= accept;
  end

  assign dflt_ready = !(pend_dflt && first_q);
  assign dflt_resp  = pend_dflt ? RESP_ERR : RESP_OKAY;
endmodule

// File: rtl/ahbl_resp_mux.sv
module ahbl_resp_mux #(
  parameter int N_RESP = 3,
  parameter int DATA_W = 32
) (
  input  logic [N_RESP-1:0]        pend_sel,
  input  logic                     pend_dflt,
  input  logic [N_RESP-1:0]        dec_sel,
  input  logic                     active,
  input  logic [N_RESP-1:0]        hreadyout,
  input  logic [N_RESP*DATA_W-1:0] hrdata,
  input  logic [N_RESP-1:0]        hresp,
  input  logic                     dflt_ready,
  input  logic                     dflt_resp,
  output logic                     ready,
  output logic [DATA_W-1:0]        rdata,
  output logic                     resp
);
  logic pend_any;
  logic pend_rdy, addr_rdy;
  assign pend_any = (|pend_sel) || pend_dflt;

  always_comb begin
    rdata    = '0;
    resp     = dflt_resp;
    pend_rdy = pend_dflt ? dflt_ready : 1'b0;
    addr_rdy = 1'b0;
    for (int i = 0; i < N_RESP; i++) begin
      if (pend_sel[i]) begin
        rdata    = rdata | hrdata[i*DATA_W +: DATA_W];
        resp     = resp | hresp[i];
        pend_rdy = pend_rdy | hreadyout[i];
      end
      if (dec_sel[i]) addr_rdy = addr_rdy | hreadyout[i];
    end
    // pending data phase outranks the live decode
    if (pend_any)                  ready = pend_rdy;
    else if (active && |dec_sel)   ready = addr_rdy;
    else                           ready = 1'b1;
  end
endmodule

// File: rtl/ahbl_addr_steer.sv
module ahbl_addr_steer #(
  parameter int N_RESP = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [N_RESP*ADDR_W-1:0] RGN_BASE =
    {32'h0001_0000, 32'h0001_0000, 32'h0000_0000},
  parameter logic [N_RESP*ADDR_W-1:0] RGN_MASK =
    {32'hFFFF_0000, 32'hFFFF_F000, 32'hFFFF_F000}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        req_haddr,
  input  logic [1:0]               req_htrans,
  output logic                     req_hready,
  output logic [DATA_W-1:0]        req_hrdata,
  output logic                     req_hresp,
  output logic [N_RESP-1:0]        rsp_hsel,
  output logic                     rsp_hready,
  input  logic [N_RESP-1:0]        rsp_hreadyout,
  input  logic [N_RESP*DATA_W-1:0] rsp_hrdata,
  input  logic [N_RESP-1:0]        rsp_hresp
);
  import ahbl_steer_pkg::*;

  logic [N_RESP-1:0] dec_sel, pend_sel;
  logic dec_miss, pend_dflt, active, dflt_ready, dflt_resp, hready;

  assign active = trans_active(req_htrans);

  ahbl_region_dec #(
    .N_RESP(N_RESP), .ADDR_W(ADDR_W), .RGN_BASE(RGN_BASE), .RGN_MASK(RGN_MASK)
  ) u_dec (
    .addr(req_haddr), .sel(dec_sel), .miss(dec_miss)
  );

  ahbl_phase_track #(.N_RESP(N_RESP)) u_track (
    .clk(clk), .rst(rst), .hready(hready), .active(active),
    .dec_sel(dec_sel), .dec_miss(dec_miss),
    .pend_sel(pend_sel), .pend_dflt(pend_dflt)
  );

  ahbl_dflt_resp u_dflt (
    .clk(clk), .rst(rst), .accept(hready && active && dec_miss),
    .pend_dflt(pend_dflt), .dflt_ready(dflt_ready), .dflt_resp(dflt_resp)
  );

  ahbl_resp_mux #(.N_RESP(N_RESP), .DATA_W(DATA_W)) u_mux (
    .pend_sel(pend_sel), .pend_dflt(pend_dflt), .dec_sel(dec_sel),
    .active(active), .hreadyout(rsp_hreadyout), .hrdata(rsp_hrdata),
    .hresp(rsp_hresp), .dflt_ready(dflt_ready), .dflt_resp(dflt_resp),
    .ready(hready), .rdata(req_hrdata), .resp(req_hresp)
  );

  assign req_hready = hready;
  assign rsp_hready = hready;
  assign rsp_hsel   = dec_sel;
endmodule

// File: rtl/ahbl_addr_steer_chk.sv
module ahbl_addr_steer_chk #(
  parameter int N_RESP = 3,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] req_haddr,
  input logic [1:0]        req_htrans,
  input logic              req_hready,
  input logic              req_hresp,
  input logic [N_RESP-1:0] rsp_hsel,
  input logic [N_RESP-1:0] rsp_hreadyout,
  input logic [N_RESP-1:0] rsp_hresp
);
  // observer of the outstanding data phase, built from port activity
  logic [N_RESP-1:0] obs_sel;
  logic              obs_dflt;
  logic              unused_addr;
  assign unused_addr = ^req_haddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      obs_sel  <= '0;
      obs_dflt <= 1'b0;
    end else if (req_hready) begin
      obs_sel  <= req_htrans[1] ? rsp_hsel : '0;
      obs_dflt <= req_htrans[1] && (rsp_hsel == '0);
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_hsel)); // R1
  AST_ADDR_READY: assert property (@(posedge clk) disable iff (rst)
    (obs_sel == '0 && !obs_dflt && req_htrans[1] && rsp_hsel != '0)
      |-> (req_hready == |(rsp_hsel & rsp_hreadyout))); // R2
  AST_PEND_READY: assert property (@(posedge clk) disable iff (rst)
    (obs_sel != '0) |-> (req_hready == |(obs_sel & rsp_hreadyout))); // R4
  AST_PEND_RESP: assert property (@(posedge clk) disable iff (rst)
    (obs_sel != '0) |-> (req_hresp == |(obs_sel & rsp_hresp))); // R6
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    (obs_sel == '0 && !obs_dflt && !req_htrans[1]) |-> req_hready); // R7
  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (req_hready && req_htrans[1] && rsp_hsel == '0)
      |=> (!req_hready && req_hresp)); // R8
  AST_ERR_SECOND: assert property (@(posedge clk) disable iff (rst)
    (obs_dflt && !req_hready) |=> (req_hready && req_hresp)); // R8
endmodule

bind ahbl_addr_steer ahbl_addr_steer_chk #(.N_RESP(N_RESP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_haddr(req_haddr), .req_htrans(req_htrans),
  .req_hready(req_hready), .req_hresp(req_hresp), .rsp_hsel(rsp_hsel),
  .rsp_hreadyout(rsp_hreadyout), .rsp_hresp(rsp_hresp)
);

// File: tb/ahbl_addr_steer_tb.sv
module ahbl_addr_steer_tb;
  localparam int N  = 3;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [AW-1:0] BASE [N] = '{32'h0000_0000, 32'h0001_0000, 32'h0001_0000};
  localparam logic [AW-1:0] MASK [N] = '{32'hFFFF_F000, 32'hFFFF_F000, 32'hFFFF_0000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0]   haddr = '0;
  logic [1:0]      htrans = 2'b00;
  logic            hready, hresp, bready;
  logic [DW-1:0]   hrdata;
  logic [N-1:0]    hsel, rout = '1, rresp = '0;
  logic [N*DW-1:0] rdat = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int pend   = -1;   // -1 none, 0..N-1 responder, N default
  bit efirst = 1'b0;

  always #5 clk = ~clk;

  ahbl_addr_steer u_dut (
    .clk(clk), .rst(rst), .req_haddr(haddr), .req_htrans(htrans),
    .req_hready(hready), .req_hrdata(hrdata), .req_hresp(hresp),
    .rsp_hsel(hsel), .rsp_hready(bready), .rsp_hreadyout(rout),
    .rsp_hrdata(rdat), .rsp_hresp(rresp)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int decode(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++)
      if ((a & MASK[i]) == (BASE[i] & MASK[i])) return i;
    return -1;
  endfunction

  // one cycle: inputs already driven after a falling edge
  task automatic step;
    int d;
    logic er, ep;
    logic [DW-1:0] ed;
    logic [N-1:0] es;
    string rq;
    #4;
    d  = decode(haddr);
    es = (d >= 0) ? (N'(1) << d) : '0;
    ed = '0; ep = 1'b0;
    if (pend >= 0 && pend < N) begin
      er = rout[pend]; ed = rdat[pend*DW +: DW]; ep = rresp[pend]; rq = "R3/R4";
    end else if (pend == N) begin
      er = !efirst; ep = 1'b1; rq = "R8";
    end else if (htrans[1] && d >= 0) begin
      er = rout[d]; rq = "R2";
    end else begin
      er = 1'b1; rq = rst ? "R9" : "R7";
    end
    chk("R1", "hsel", 64'(hsel), 64'(es));
    chk(rq, "hready", 64'(hready), 64'(er));
    chk("R5", "bcast", 64'(bready), 64'(er));
    chk(pend == N ? "R8" : "R6", "hrdata", 64'(hrdata), 64'(ed));
    chk(pend == N ? "R8" : "R6", "hresp", 64'(hresp), 64'(ep));
    @(posedge clk);
    if (rst) begin
      pend = -1; efirst = 1'b0;
    end else if (er) begin
      pend   = htrans[1] ? ((d >= 0) ? d : N) : -1;
      efirst = htrans[1] && (d < 0);
    end else begin
      efirst = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic [1:0] t, input logic [N-1:0] r);
    haddr = a; htrans = t; rout = r;
    for (int i = 0; i < N; i++) rdat[i*DW +: DW] = $urandom;
    rresp = N'($urandom);
    step();
  endtask

  function automatic logic [AW-1:0] pick_addr(input int k);
    case (k % 8)
      0: return 32'h0000_0000;
      1: return 32'h0000_0FFC;
      2: return 32'h0001_0000;   // overlap, R1 wins
      3: return 32'h0001_0FFC;
      4: return 32'h0001_1000;   // R2 only
      5: return 32'h0001_FFFC;
      6: return 32'h0000_2000;   // unmapped
      default: return 32'h8000_0000;
    endcase
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    drive(32'h0, 2'b00, 3'b111);                 // R9 reset state
    rst = 1'b0;
    drive(32'h0, 2'b00, 3'b000);                 // R7 idle
    drive(32'h0000_0010, 2'b10, 3'b001);         // R2 to resp 0
    drive(32'h0001_1000, 2'b10, 3'b100);         // R4 wait: pend 0 low ready
    drive(32'h0001_1000, 2'b10, 3'b101);         // R3 complete, capture resp 2
    drive(32'h0001_0004, 2'b11, 3'b011);         // R4 resp 2 not ready
    drive(32'h0001_0004, 2'b11, 3'b110);         // R1 overlap -> resp 1
    drive(32'h0000_2000, 2'b10, 3'b111);         // unmapped accept R8
    drive(32'h0000_0000, 2'b10, 3'b000);         // R8 first cycle
    drive(32'h0000_0000, 2'b10, 3'b000);         // R8 second cycle (resp0 not ready not used)
    drive(32'h8000_0000, 2'b10, 3'b001);         // data resp 0, accept unmapped
    drive(32'h0, 2'b00, 3'b111);                 // error first
    drive(32'h0, 2'b00, 3'b111);                 // error second, R3 clear
    drive(32'h0, 2'b01, 3'b000);                 // R7 BUSY
    for (int n = 0; n < 3000; n++)
      drive(pick_addr($urandom), 2'($urandom), N'($urandom));
    rst = 1'b1;
    drive(32'h0001_0000, 2'b10, 3'b000);         // reset dominates capture
    drive(32'h0, 2'b00, 3'b000);                 // R9
    rst = 1'b0;
    drive(32'h0, 2'b00, 3'b000);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule